// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Lookup

This block is a 16 KB read cache with write-through stores. It sits between a processor-side request port and a memory-side line port. Storage is organised as 256 sets. Each set holds two ways, and each way holds a tag, a valid bit and a 32-byte line. A request is looked up in the cycle it is accepted: both ways of the indexed set compare their tags at once, and the matching way's word is selected onto the response.

On a read miss the request port stalls. A line request goes to memory, and the returned 32-byte line is written into the way that was not used most recently in that set. Each set keeps one bit that records its most recently used way. Writes always pass straight through to memory. A write that hits also updates the cached word. A write that misses leaves the cache untouched.

Top module: `two_way_cache_lookup`

## Requirements
- R1: A byte address is split into byte offset = bits [4:0], set index = bits [12:5] and tag = bits [31:13]; the word within a line is chosen by bits [4:2]. For example, 0x12345678 selects set 179 with tag 0x091A2 and word 6, and its line request carries address 0x12345660.
- R2: After reset every line is invalid and the response, line-request and write-through outputs are low with the request port ready, so the first read of any address misses.
- R3: An accepted read that hits raises respValid with respHit=1 and the stored word exactly one cycle after acceptance, and issues no line request.
- R4: Two lines whose addresses share a set index but differ in tag can both be resident at once, and each then hits.
- R5: An accepted read that misses raises memReqValid on the next cycle with the line-aligned address and keeps reqReady low until memFillValid is seen. One cycle after the fill the block answers with respHit=0 and the requested word taken from the fill data.
- R6: A refill replaces the way of the set that was not accessed most recently; any hit, read or write, marks its way as most recently accessed.
- R7: A write hit replaces the addressed 32-bit word in the hitting way, so later reads of it return the written value.
- R8: A write miss fetches no line and changes no cache content; a later read of the same address still misses.
- R9: Every accepted write, hit or miss, produces memWrValid for one cycle on the following cycle, carrying the request's address and data, and a write answers with respValid one cycle after acceptance.
- R10: memFillValid while no refill is pending has no effect: no response is produced and no line becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the request |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | Request accepted on this edge when high |
| respValid | output | 1 | Response present |
| respHit | output | 1 | Response came from a resident line |
| respRdata | output | 32 | Read word (zero for writes) |
| memReqValid | output | 1 | Line fetch outstanding |
| memReqAddr | output | 32 | Line-aligned fetch address |
| memFillValid | input | 1 | Fill line present |
| memFillData | input | 256 | Whole line, word k in bits [32k+31:32k] |
| memWrValid | output | 1 | Write-through strobe |
| memWrAddr | output | 32 | Write-through address |
| memWrData | output | 32 | Write-through data |

## Verification
The bench builds the block with its defaults: 32-bit addresses and words, 32-byte lines and 256 sets. That gives the 19-bit tag and the 8-bit index that the address example depends on. With these values, addresses that differ only at bit 13 and above land in the same set, so a third tag can be forced into one set to show which way is evicted and how a write hit changes that choice. The 256-bit fill lets the bench check the word selection and the line-aligned request address of a single decoded address.

// File: rtl/cache_lookup_pkg.sv
package cache_lookup_pkg;

  // Strobes issued by the control FSM to the datapath each cycle.
  typedef struct packed {
    logic accept;     // request taken on this edge
    logic respond;    // answer now from the lookup result
    logic touch;      // hit: record hitting way as most recent
    logic writeWord;  // write hit: update one word in the hitting way
    logic fill;       // refill line lands in the victim way
  } ctrlStrobes_t;

  typedef enum logic {
    ST_IDLE,
    ST_REFILL
  } ctrlState_t;

endpackage

// File: rtl/cache_control.sv
module cache_control
  import cache_lookup_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         lookupHit,
  input  logic         memFillValid,
  output ctrlStrobes_t strb,
  output logic         reqReady,
  output logic         memReqValid
);

  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.accept    = 1'b1;
          strb.touch     = lookupHit;
          strb.writeWord = lookupHit && reqWrite;
          if (!reqWrite && !lookupHit) stateNext    = ST_REFILL;
          else                         strb.respond = 1'b1;
        end
      end
      ST_REFILL: begin
        if (memFillValid) begin
          strb.fill = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_REFILL);

endmodule

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_lookup_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_SETS   = 256
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strb,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [WORD_W-1:0]         reqWdata,
  input  logic [LINE_BYTES*8-1:0]   memFillData,
  output logic                      lookupHit,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic                      respValid,
  output logic                      respHit,
  output logic [WORD_W-1:0]         respRdata,
  output logic                      memWrValid,
  output logic [ADDR_W-1:0]         memWrAddr,
  output logic [WORD_W-1:0]         memWrData
);

  localparam int WAYS       = 2;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(NUM_SETS);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int BYTE_SEL_W = $clog2(WORD_W / 8);
  localparam int WORD_SEL_W = OFF_W - BYTE_SEL_W;

  // Field extraction for the live request and the pending miss.
  logic [ADDR_W-1:0]     pendAddr;
  logic [IDX_W-1:0]      reqIdx, pendIdx;
  logic [TAG_W-1:0]      reqTag, pendTag;
  logic [WORD_SEL_W-1:0] reqWordSel, pendWordSel;

  assign reqIdx      = reqAddr[OFF_W +: IDX_W];
  assign reqTag      = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqWordSel  = reqAddr[BYTE_SEL_W +: WORD_SEL_W];
  assign pendIdx     = pendAddr[OFF_W +: IDX_W];
  assign pendTag     = pendAddr[ADDR_W-1 -: TAG_W];
  assign pendWordSel = pendAddr[BYTE_SEL_W +: WORD_SEL_W];

  logic unusedLowBits;
  assign unusedLowBits = ^{reqAddr[BYTE_SEL_W-1:0], pendAddr[BYTE_SEL_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pendAddr <= '0;
    else if (strb.accept) pendAddr <= reqAddr;
  end

  assign memReqAddr = {pendAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  // One most-recently-used bit per set; the victim is the other way.
  logic [NUM_SETS-1:0] mruBits;
  logic [WAYS-1:0]     wayHit;
  logic [WORD_W-1:0]   wayWord [WAYS];
  logic                victimWay, hitWay;

  assign victimWay = ~mruBits[pendIdx];
  assign hitWay    = wayHit[1];
  assign lookupHit = |wayHit;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]    tagMem  [NUM_SETS];
    logic [LINE_W-1:0]   dataMem [NUM_SETS];
    logic [NUM_SETS-1:0] validBits;
    logic                isVictim;

    assign isVictim = (victimWay == 1'(w));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      validBits          <= '0;
      else if (strb.fill && isVictim) validBits[pendIdx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (strb.fill && isVictim) begin
        tagMem[pendIdx]  <= pendTag;
        dataMem[pendIdx] <= memFillData;
      end else if (strb.writeWord && wayHit[w]) begin
        dataMem[reqIdx][reqWordSel*WORD_W +: WORD_W] <= reqWdata;
      end
    end

    assign wayHit[w]  = validBits[reqIdx] && (tagMem[reqIdx] == reqTag);
    assign wayWord[w] = dataMem[reqIdx][reqWordSel*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           mruBits          <= '0;
    else if (strb.fill)  mruBits[pendIdx] <= victimWay;
    else if (strb.touch) mruBits[reqIdx]  <= hitWay;
  end

  // Response register: from the lookup or from the arriving line.
  logic [WORD_W-1:0] hitWord, fillWord;
  assign hitWord  = hitWay ? wayWord[1] : wayWord[0];
  assign fillWord = memFillData[pendWordSel*WORD_W +: WORD_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respRdata <= '0;
    end else if (strb.respond) begin
      respValid <= 1'b1;
      respHit   <= lookupHit;
      respRdata <= (reqWrite || !lookupHit) ? '0 : hitWord;
    end else if (strb.fill) begin
      respValid <= 1'b1;
      respHit   <= 1'b0;
      respRdata <= fillWord;
    end else begin
      respValid <= 1'b0;
    end
  end

  // Write-through path: every accepted write goes to memory.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWrValid <= 1'b0;
      memWrAddr  <= '0;
      memWrData  <= '0;
    end else begin
      memWrValid <= strb.accept && reqWrite;
      if (strb.accept && reqWrite) begin
        memWrAddr <= reqAddr;
        memWrData <= reqWdata;
      end
    end
  end

endmodule

// File: rtl/two_way_cache_lookup.sv
module two_way_cache_lookup
  import cache_lookup_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_SETS   = 256
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [WORD_W-1:0]       reqWdata,
  output logic                    reqReady,
  output logic                    respValid,
  output logic                    respHit,
  output logic [WORD_W-1:0]       respRdata,
  output logic                    memReqValid,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memFillValid,
  input  logic [LINE_BYTES*8-1:0] memFillData,
  output logic                    memWrValid,
  output logic [ADDR_W-1:0]       memWrAddr,
  output logic [WORD_W-1:0]       memWrData
);

  ctrlStrobes_t strb;
  logic         lookupHit;

  cache_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .lookupHit    (lookupHit),
    .memFillValid (memFillValid),
    .strb         (strb),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid)
  );

  cache_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_BYTES (LINE_BYTES),
    .NUM_SETS   (NUM_SETS)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .memFillData (memFillData),
    .lookupHit   (lookupHit),
    .memReqAddr  (memReqAddr),
    .respValid   (respValid),
    .respHit     (respHit),
    .respRdata   (respRdata),
    .memWrValid  (memWrValid),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData)
  );

endmodule

// File: rtl/cache_lookup_checker.sv
module cache_lookup_checker #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [WORD_W-1:0] reqWdata,
  input logic              reqReady,
  input logic              respValid,
  input logic              respHit,
  input logic              memReqValid,
  input logic              memFillValid,
  input logic              memWrValid,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [WORD_W-1:0] memWrData
);

  // R5: the request port is stalled while a line fetch is outstanding.
  assert_stall_during_fetch_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R5: a fetch only starts after an accepted read.
  assert_fetch_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(reqValid && reqReady && !reqWrite));

  // R5: the fill ends the fetch and yields a miss response next cycle.
  assert_fill_completes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memFillValid) |=> (!memReqValid && respValid && !respHit));

  // R8: a write never starts a line fetch.
  assert_write_no_fetch_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> !memReqValid);

  // R9: each accepted write is forwarded with its address and data.
  assert_write_forwarded_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=>
      (memWrValid && memWrAddr == $past(reqAddr) && memWrData == $past(reqWdata)));

  // R9: no write-through strobe without an accepted write.
  assert_write_strobe_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> $past(reqValid && reqReady && reqWrite));

  // R10: a response only follows an accepted request or a pending fill.
  assert_resp_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past((reqValid && reqReady) || (memReqValid && memFillValid)));

endmodule

bind two_way_cache_lookup cache_lookup_checker #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W)
) i_checker (.*);

// File: tb/test_two_way_cache_lookup.sv
module test_two_way_cache_lookup;
  timeunit 1ns;
  timeprecision 100ps;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [31:0]  reqAddr = '0;
  logic [31:0]  reqWdata = '0;
  logic         reqReady;
  logic         respValid;
  logic         respHit;
  logic [31:0]  respRdata;
  logic         memReqValid;
  logic [31:0]  memReqAddr;
  logic         memFillValid = 1'b0;
  logic [255:0] memFillData = '0;
  logic         memWrValid;
  logic [31:0]  memWrAddr;
  logic [31:0]  memWrData;

  always #2.5 clk = ~clk;

  two_way_cache_lookup i_two_way_cache_lookup (.*);

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Memory model: untouched words hold {addr[15:0], ~addr[15:0]}.
  logic [31:0] shadow [logic [31:0]];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic logic [31:0] memWord(input logic [31:0] a);
    if (shadow.exists(a)) return shadow[a];
    return pat(a);
  endfunction

  function automatic logic [255:0] buildLine(input logic [31:0] lineAddr);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = memWord(lineAddr + 32'(4*k));
    return l;
  endfunction

  // Results of the last access.
  bit          rHit, rSawFetch, rStallOk, rSawWr, rGotResp;
  logic [31:0] rData, rFetchAddr, rWrAddr, rWrData;
  int          rLat;

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd);
    rSawFetch = 0; rStallOk = 1; rSawWr = 0; rGotResp = 0; rLat = 0;
    rFetchAddr = '0; rWrAddr = '0; rWrData = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    rLat = 1;
    if (memWrValid) begin
      rSawWr = 1; rWrAddr = memWrAddr; rWrData = memWrData;
      shadow[memWrAddr] = memWrData;
    end
    while (!respValid && rLat < 20) begin
      if (memReqValid) begin
        rSawFetch  = 1;
        rFetchAddr = memReqAddr;
        if (reqReady) rStallOk = 0;
        memFillValid = 1'b1;
        memFillData  = buildLine(memReqAddr);
        @(negedge clk);
        memFillValid = 1'b0;
      end else begin
        @(negedge clk);
      end
      rLat++;
    end
    rGotResp = respValid;
    rHit  = respHit;
    rData = respRdata;
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        expHit;
    logic        chkData;
    logic [31:0] expData;
  } vec_t;

  localparam int NV = 18;
  // Set 2 hosts tags 0 (0x0040), 1 (0x2040) and 2 (0x4040) to drive R4/R6/R7.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0044, 32'h0, 1'b0, 1'b1, 32'h0044_FFBB}, // cold miss
    '{1'b0, 32'h0000_0044, 32'h0, 1'b1, 1'b1, 32'h0044_FFBB}, // hit
    '{1'b0, 32'h0000_2048, 32'h0, 1'b0, 1'b1, 32'h2048_DFB7}, // second way fills
    '{1'b0, 32'h0000_0044, 32'h0, 1'b1, 1'b1, 32'h0044_FFBB}, // both resident
    '{1'b0, 32'h0000_2048, 32'h0, 1'b1, 1'b1, 32'h2048_DFB7},
    '{1'b0, 32'h0000_005C, 32'h0, 1'b1, 1'b1, 32'h005C_FFA3}, // last word of line
    '{1'b0, 32'h0000_4040, 32'h0, 1'b0, 1'b1, 32'h4040_BFBF}, // evicts 0x2040
    '{1'b0, 32'h0000_0044, 32'h0, 1'b1, 1'b1, 32'h0044_FFBB}, // recent line kept
    '{1'b0, 32'h0000_2048, 32'h0, 1'b0, 1'b1, 32'h2048_DFB7}, // evicted line misses
    '{1'b1, 32'h0000_0048, 32'h1122_3344, 1'b1, 1'b0, 32'h0}, // write hit
    '{1'b0, 32'h0000_4040, 32'h0, 1'b0, 1'b1, 32'h4040_BFBF}, // write made 0x0040 recent
    '{1'b0, 32'h0000_0048, 32'h0, 1'b1, 1'b1, 32'h1122_3344}, // written word read back
    '{1'b0, 32'h0000_2048, 32'h0, 1'b0, 1'b1, 32'h2048_DFB7},
    '{1'b1, 32'h0000_8100, 32'hCAFE_F00D, 1'b0, 1'b0, 32'h0}, // write miss
    '{1'b0, 32'h0000_8100, 32'h0, 1'b0, 1'b1, 32'hCAFE_F00D}, // not allocated
    '{1'b0, 32'h0000_8100, 32'h0, 1'b1, 1'b1, 32'hCAFE_F00D},
    '{1'b0, 32'h1234_5678, 32'h0, 1'b0, 1'b1, 32'h5678_A987}, // decode example
    '{1'b0, 32'h1234_5664, 32'h0, 1'b1, 1'b1, 32'h5664_A99B}  // same line, word 1
  };

  task automatic checkVector(input int i, input vec_t v);
    string tag;
    tag = v.expHit ? "R3" : (v.wr ? "R8" : "R5");
    check(rGotResp == 1'b1, tag, $sformatf("step %0d response", i), 32'(rGotResp), 32'd1);
    check(rHit == v.expHit, tag, $sformatf("step %0d hit", i), 32'(rHit), 32'(v.expHit));
    if (v.chkData)
      check(rData == v.expData, "R7", $sformatf("step %0d data", i), rData, v.expData);
    if (!v.wr && !v.expHit) begin
      // R5 / R1: line-aligned fetch, stall, answer one cycle after fill
      check(rSawFetch && rFetchAddr == (v.addr & 32'hFFFF_FFE0), "R1",
            $sformatf("step %0d fetch addr", i), rFetchAddr, v.addr & 32'hFFFF_FFE0);
      check(rStallOk, "R5", $sformatf("step %0d stall", i), 32'(rStallOk), 32'd1);
      check(rLat == 2, "R5", $sformatf("step %0d latency", i), 32'(rLat), 32'd2);
    end else begin
      check(!rSawFetch && rLat == 1, "R3", $sformatf("step %0d no fetch, 1 cycle", i),
            32'(rLat), 32'd1);
    end
    if (v.wr) begin
      check(rSawWr && rWrAddr == v.addr, "R9", $sformatf("step %0d wr addr", i), rWrAddr, v.addr);
      check(rWrData == v.wdata, "R9", $sformatf("step %0d wr data", i), rWrData, v.wdata);
    end else begin
      check(!rSawWr, "R9", $sformatf("step %0d no wr strobe", i), 32'(rSawWr), 32'd0);
    end
  endtask

  task automatic checkIdleOutputs(input string what);
    check(reqReady == 1'b1, "R2", {what, " reqReady"}, 32'(reqReady), 32'd1);
    check(respValid == 1'b0, "R2", {what, " respValid"}, 32'(respValid), 32'd0);
    check(memReqValid == 1'b0, "R2", {what, " memReqValid"}, 32'(memReqValid), 32'd0);
    check(memWrValid == 1'b0, "R2", {what, " memWrValid"}, 32'(memWrValid), 32'd0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdleOutputs("reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdleOutputs("after reset");

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
      checkVector(i, VECS[i]);
    end

    // R1: same set 179, tag 0x091A3 differs at bit 13 -> misses, then both ways hit
    access(1'b0, 32'h1234_7678, 32'h0);
    check(!rHit && rFetchAddr == 32'h1234_7660, "R1", "other tag same set misses",
          rFetchAddr, 32'h1234_7660);
    access(1'b0, 32'h1234_5678, 32'h0);
    check(rHit && rData == 32'h5678_A987, "R4", "first tag still resident", rData, 32'h5678_A987);
    access(1'b0, 32'h1234_7678, 32'h0);
    check(rHit && rData == 32'h7678_8987, "R4", "second tag resident", rData, 32'h7678_8987);

    // R10: stray fill while idle is ignored
    @(negedge clk);
    memFillValid = 1'b1;
    memFillData  = {8{32'h7777_7777}};
    @(negedge clk);
    memFillValid = 1'b0;
    check(respValid == 1'b0, "R10", "no response to stray fill", 32'(respValid), 32'd0);
    access(1'b0, 32'h0000_0300, 32'h0);
    check(!rHit && rData == 32'h0300_FCFF, "R10", "stray fill made nothing valid",
          rData, 32'h0300_FCFF);

    // R2: reset in mid-run invalidates resident lines
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkIdleOutputs("mid-run reset");
    rstN = 1'b1;
    access(1'b0, 32'h0000_0044, 32'h0);
    check(rGotResp && !rHit, "R2", "resident line invalid after reset", 32'(rHit), 32'd0);
    check(rData == 32'h0044_FFBB, "R2", "refetched data", rData, 32'h0044_FFBB);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule